// File: doc/BRIEF.md
# Parallel-port extended control register with transfer FIFO

This block holds the extended control register and the byte FIFO of a parallel port that supports FIFO-based transfer modes. The host reaches it through a small high register window: offset 2 is the control register, offset 0 is the FIFO data port (or the first configuration byte while in configuration mode) and offset 1 is the second configuration byte. The control register carries a three-bit mode field, the DMA enable, the error-interrupt disable and the service bit, and it reports live FIFO empty and full status.

On the other side, a pin handshake engine (not part of this block) drains the FIFO in the forward direction or fills it in the reverse direction. The service bit is set by hardware when the FIFO crosses a write threshold (forward) or a read threshold (reverse), so software can move a known number of bytes per service event. A test mode lets the host fill and empty the FIFO itself with no engine activity; this is how software discovers depth and thresholds. Choosing one of the two basic modes empties the FIFO, and a direct hop between two FIFO modes is refused.

Top module: `ecp_ctl_fifo`

## Requirements
- R1: The control register (offset 2) reads as {mode[2:0], err_dis, dma_en, svc, full, empty} from bit 7 down to bit 0; mode codes are 000 standard, 001 bidirectional, 010 FIFO, 011 extended, 110 test, 111 configuration, and reset leaves mode 000 with the register reading 0x01.
- R2: Bits 1 (full) and 0 (empty) are read-only status; writing 1s to them changes nothing read back.
- R3: Bits 4, 3 and 2 read back as last written; writing 0x34 with an empty FIFO reads back 0x35.
- R4: Any control write whose mode field is 000 or 001 empties the FIFO.
- R5: A write that would change the mode from one code of 010 or above to a different code of 010 or above leaves the mode unchanged, while bits 4:2 are still written.
- R6: In test mode host writes to offset 0 push bytes and host reads from offset 0 pop them in write order; full reads 1 after DEPTH bytes, a push to a full FIFO is dropped, and a read of an empty FIFO returns 0x00 and changes nothing.
- R7: With the reverse input low, the service bit sets when a pop raises the free space from below WR_THR to WR_THR or more.
- R8: With the reverse input high, the service bit sets when a push raises the fill level from below RD_THR to RD_THR or more.
- R9: The service bit sets only on such a crossing or a host write of 1; it stays set until a host write of 0 clears it, and a later pop that does not cross does not set it again.
- R10: In configuration mode, offset 0 reads the CFGA_ID parameter and offset 1 reads {2'b00, irq_line[2:0], dma_channel[2:0]}; outside configuration mode offset 1 reads 0x00.
- R11: The interrupt-line field encodes interrupt numbers 7, 9, 10, 11, 14, 15, 5 as codes 1 to 7, and any other number as 0.
- R12: In FIFO or extended mode with reverse low, the engine pops bytes in host write order through eng_pop/eng_rdata with eng_avail high while bytes remain; in extended mode with reverse high, engine pushes are read by the host at offset 0 in order.
- R13: mode_o, dma_en_o and svc_o always equal the mode field, bit 3 and bit 2 of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a FIFO read pops at the clock edge) |
| host_addr | input | 2 | Offset within the high window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| dir_rev | input | 1 | Transfer direction from the port control register: 1 = reverse |
| eng_push | input | 1 | Engine pushes a received byte (extended mode, reverse) |
| eng_wdata | input | 8 | Byte pushed by the engine |
| eng_pop | input | 1 | Engine takes the head byte (forward) |
| eng_rdata | output | 8 | Head byte of the FIFO |
| eng_avail | output | 1 | A byte is available to the engine in forward FIFO modes |
| mode_o | output | 3 | Current mode field |
| dma_en_o | output | 1 | DMA enable bit |
| svc_o | output | 1 | Service bit |

## Verification
The checker watches on every cycle that the fill level never passes the depth, that empty and full are never both reported, that a basic-mode write leaves the FIFO empty, that a direct hop between FIFO modes does not move the mode, that a control read reflects mode and empty, and that the service bit rises only after a threshold crossing or a host write of 1. Byte ordering through both the host and engine paths, the exact pop or push on which each threshold fires, the silence of non-crossing pops after a clear, the dropped seventeenth byte and the configuration bytes for two different interrupt and DMA settings are shown only by the bench's scenarios.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    typedef enum logic [2:0] {
        MD_STD   = 3'b000,
        MD_BIDIR = 3'b001,
        MD_PPF   = 3'b010,
        MD_EXT   = 3'b011,
        MD_RSV4  = 3'b100,
        MD_RSV5  = 3'b101,
        MD_TEST  = 3'b110,
        MD_CFG   = 3'b111
    } ecp_mode_e;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_CFGB = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;

    typedef struct packed {
        ecp_mode_e mode;
        logic      err_dis;
        logic      dma_en;
        logic      svc;
    } ecr_ctl_t;

    // Codes 010 and above use the FIFO.
    function automatic logic is_fifo_mode(input ecp_mode_e m);
        return m[2] | m[1];
    endfunction

    // Interrupt number to the three-bit line code of config B.
    function automatic logic [2:0] irq_to_line(input int irq);
        case (irq)
            7:       return 3'd1;
            9:       return 3'd2;
            10:      return 3'd3;
            11:      return 3'd4;
            14:      return 3'd5;
            15:      return 3'd6;
            5:       return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_comb begin
        if (clr) cnt_nxt = '0;
        else     cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            cnt <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/ecp_thresh.sv
module ecp_thresh #(
    parameter int DEPTH  = 16,
    parameter int WR_THR = 6,
    parameter int RD_THR = 10,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          active,
    input  logic          dir_rev,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    output logic          hit
);

    logic [CW-1:0] free_cur, free_nxt;
    logic          fwd_cross, rev_cross;

    assign free_cur  = CW'(DEPTH) - cnt;
    assign free_nxt  = CW'(DEPTH) - cnt_nxt;
    assign fwd_cross = (free_cur < CW'(WR_THR)) && (free_nxt >= CW'(WR_THR));
    assign rev_cross = (cnt < CW'(RD_THR)) && (cnt_nxt >= CW'(RD_THR));
    assign hit       = active & (dir_rev ? rev_cross : fwd_cross);

endmodule

// File: rtl/ecp_ecr.sv
module ecp_ecr
    import ecp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:2] wdata,
    input  logic       hit,
    output ecr_ctl_t   ctl,
    output logic       clr_req
);

    ecp_mode_e req_mode;
    logic      hop_block;

    assign req_mode  = ecp_mode_e'(wdata[7:5]);
    assign hop_block = is_fifo_mode(ctl.mode) && is_fifo_mode(req_mode)
                       && (req_mode != ctl.mode);
    assign clr_req   = wr && (wdata[7:6] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{mode: MD_STD, err_dis: 1'b0, dma_en: 1'b0, svc: 1'b0};
        end else if (wr) begin
            if (!hop_block) ctl.mode <= req_mode;
            ctl.err_dis <= wdata[4];
            ctl.dma_en  <= wdata[3];
            ctl.svc     <= wdata[2];
        end else if (hit) begin
            ctl.svc <= 1'b1;
        end
    end

endmodule

// File: rtl/ecp_ctl_fifo.sv
module ecp_ctl_fifo
    import ecp_pkg::*;
#(
    parameter int         DEPTH   = 16,
    parameter int         WR_THR  = 6,
    parameter int         RD_THR  = 10,
    parameter int         DMA_CH  = 3,
    parameter int         IRQ_NUM = 7,
    parameter logic [7:0] CFGA_ID = 8'h10,
    localparam int        CW      = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       dir_rev,
    input  logic       eng_push,
    input  logic [7:0] eng_wdata,
    input  logic       eng_pop,
    output logic [7:0] eng_rdata,
    output logic       eng_avail,
    output logic [2:0] mode_o,
    output logic       dma_en_o,
    output logic       svc_o
);

    ecr_ctl_t      ctl;
    logic          ecr_wr, fifo_clr;
    logic          host_push, host_pop, eng_push_ok, eng_pop_ok;
    logic          fifo_push, fifo_pop;
    logic [7:0]    fifo_din, fifo_dout;
    logic [CW-1:0] fifo_cnt, fifo_cnt_nxt;
    logic          fifo_empty, fifo_full, thr_hit;
    logic          host_fifo_rd_mode, eng_fwd_mode;
    logic [7:0]    cfgb;

    assign ecr_wr = host_wr && (host_addr == ADR_CTRL);

    ecp_ecr u_ecr (
        .clk     (clk),
        .rst     (rst),
        .wr      (ecr_wr),
        .wdata   (host_wdata[7:2]),
        .hit     (thr_hit),
        .ctl     (ctl),
        .clr_req (fifo_clr)
    );

    // Which side may touch the FIFO in the current mode and direction.
    assign host_fifo_rd_mode = (ctl.mode == MD_TEST) || ((ctl.mode == MD_EXT) && dir_rev);
    assign eng_fwd_mode      = ((ctl.mode == MD_PPF) || (ctl.mode == MD_EXT)) && !dir_rev;

    assign host_push   = host_wr && (host_addr == ADR_DATA) &&
                         ((ctl.mode == MD_PPF) || (ctl.mode == MD_TEST) ||
                          ((ctl.mode == MD_EXT) && !dir_rev));
    assign host_pop    = host_rd && (host_addr == ADR_DATA) && host_fifo_rd_mode;
    assign eng_push_ok = eng_push && dir_rev && (ctl.mode == MD_EXT);
    assign eng_pop_ok  = eng_pop && eng_fwd_mode;

    assign fifo_push = host_push | eng_push_ok;
    assign fifo_pop  = host_pop | eng_pop_ok;
    assign fifo_din  = eng_push_ok ? eng_wdata : host_wdata;

    ecp_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr),
        .push    (fifo_push),
        .pop     (fifo_pop),
        .din     (fifo_din),
        .dout    (fifo_dout),
        .cnt     (fifo_cnt),
        .cnt_nxt (fifo_cnt_nxt),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    ecp_thresh #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_thr (
        .active  (is_fifo_mode(ctl.mode) && !fifo_clr),
        .dir_rev (dir_rev),
        .cnt     (fifo_cnt),
        .cnt_nxt (fifo_cnt_nxt),
        .hit     (thr_hit)
    );

    assign cfgb = {2'b00, irq_to_line(IRQ_NUM), 3'(DMA_CH)};

    always_comb begin
        host_rdata = 8'h00;
        case (host_addr)
            ADR_DATA: begin
                if (ctl.mode == MD_CFG)     host_rdata = CFGA_ID;
                else if (host_fifo_rd_mode) host_rdata = fifo_dout;
            end
            ADR_CFGB: begin
                if (ctl.mode == MD_CFG) host_rdata = cfgb;
            end
            ADR_CTRL: host_rdata = {ctl.mode, ctl.err_dis, ctl.dma_en, ctl.svc,
                                    fifo_full, fifo_empty};
            default:  host_rdata = 8'h00;
        endcase
    end

    assign eng_rdata = fifo_dout;
    assign eng_avail = eng_fwd_mode && !fifo_empty;
    assign mode_o    = ctl.mode;
    assign dma_en_o  = ctl.dma_en;
    assign svc_o     = ctl.svc;

endmodule

// File: rtl/ecp_ctl_fifo_chk.sv
module ecp_ctl_fifo_chk #(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic          host_rd,
    input logic [1:0]    host_addr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic [2:0]    mode_o,
    input logic          svc_o,
    input logic [CW-1:0] fifo_cnt,
    input logic          fifo_empty,
    input logic          fifo_full,
    input logic          thr_hit
);

    logic ctrl_wr;
    assign ctrl_wr = host_wr && (host_addr == 2'd2);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full));

    a_r4_basic_mode_empties: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && host_wdata[7:6] == 2'b00) |=> fifo_empty);

    a_r5_no_direct_hop: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && (mode_o[2] | mode_o[1]) && (host_wdata[7] | host_wdata[6])
         && host_wdata[7:5] != mode_o) |=> $stable(mode_o));

    a_r9_svc_source: assert property (@(posedge clk) disable iff (rst)
        $rose(svc_o) |-> $past(thr_hit || (ctrl_wr && host_wdata[2])));

    a_r1_ctrl_read: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'd2) |-> (host_rdata[7:5] == mode_o
                                            && host_rdata[0] == fifo_empty));

endmodule

bind ecp_ctl_fifo ecp_ctl_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .mode_o     (mode_o),
    .svc_o      (svc_o),
    .fifo_cnt   (fifo_cnt),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .thr_hit    (thr_hit)
);

// File: tb/ecp_ctl_fifo_bench.sv
module ecp_ctl_fifo_bench;

    localparam int DEPTH  = 16;
    localparam int WR_THR = 6;
    localparam int RD_THR = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata, alt_rdata;
    logic       dir_rev = 1'b0;
    logic       eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] eng_wdata = 8'h00;
    logic [7:0] eng_rdata, alt_eng_rdata;
    logic       eng_avail, alt_eng_avail;
    logic [2:0] mode_o, alt_mode;
    logic       dma_en_o, svc_o, alt_dma, alt_svc;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] rd_v, alt_v;

    always #10 clk = ~clk;

    ecp_ctl_fifo #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR),
                   .DMA_CH(3), .IRQ_NUM(7), .CFGA_ID(8'h10)) u_ecp_ctl_fifo (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dir_rev(dir_rev), .eng_push(eng_push), .eng_wdata(eng_wdata),
        .eng_pop(eng_pop), .eng_rdata(eng_rdata), .eng_avail(eng_avail),
        .mode_o(mode_o), .dma_en_o(dma_en_o), .svc_o(svc_o));

    ecp_ctl_fifo #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR),
                   .DMA_CH(1), .IRQ_NUM(14), .CFGA_ID(8'h10)) u_ecp_ctl_fifo_alt (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(alt_rdata),
        .dir_rev(dir_rev), .eng_push(1'b0), .eng_wdata(8'h00),
        .eng_pop(1'b0), .eng_rdata(alt_eng_rdata), .eng_avail(alt_eng_avail),
        .mode_o(alt_mode), .dma_en_o(alt_dma), .svc_o(alt_svc));

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2 rd_v = host_rdata; alt_v = alt_rdata;
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    // Driver: writes a byte and records it when the FIFO should keep it.
    task automatic fifo_put(input logic [7:0] d, input bit kept);
        host_write(2'd0, d);
        if (kept) exp_q.push_back(d);
    endtask

    // Monitor side of the scoreboard for the host read path.
    task automatic fifo_get(input string tag);
        logic [7:0] e;
        host_read(2'd0);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        check(tag, rd_v, e);
    endtask

    task automatic eng_take(input string tag);
        logic [7:0] e;
        @(negedge clk);
        eng_pop = 1'b1;
        #2 e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        check(tag, eng_rdata, e);
        @(posedge clk); #1 eng_pop = 1'b0;
    endtask

    task automatic eng_give(input logic [7:0] d);
        @(negedge clk);
        eng_push = 1'b1; eng_wdata = d;
        @(posedge clk); #1 eng_push = 1'b0;
        exp_q.push_back(d);
    endtask

    task automatic ctrl_expect(input string tag, input logic [7:0] e);
        host_read(2'd2);
        check(tag, rd_v, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        ctrl_expect("R1 reset value", 8'h01);
        check("R13 reset svc_o", {7'd0, svc_o}, 8'h00);

        host_write(2'd2, 8'h34);
        ctrl_expect("R3 write 0x34 reads 0x35", 8'h35);
        check("R13 mode_o bidirectional", {5'd0, mode_o}, 8'h01);
        check("R13 svc_o follows bit 2", {7'd0, svc_o}, 8'h01);

        host_write(2'd2, 8'hC0);
        ctrl_expect("R1 test mode code", 8'hC1);
        host_write(2'd2, 8'hC3);
        ctrl_expect("R2 status bits read-only", 8'hC1);

        // R6 loopback, full flag, drop on full, empty read.
        for (int i = 0; i < DEPTH; i++) fifo_put(8'(8'h30 + i), 1'b1);
        ctrl_expect("R6 full after depth", 8'hC2);
        fifo_put(8'hEE, 1'b0);
        ctrl_expect("R6 full unchanged by extra push", 8'hC2);
        for (int i = 0; i < DEPTH; i++) fifo_get("R6 loopback order");
        ctrl_expect("R7 drain crossed write threshold", 8'hC5);
        fifo_get("R6 empty read returns zero");
        ctrl_expect("R6 empty read changes nothing", 8'hC5);

        // R7 / R9 forward threshold.
        for (int i = 0; i < DEPTH; i++) fifo_put(8'(8'hA0 + i), 1'b1);
        host_write(2'd2, 8'hC0);
        for (int i = 0; i < WR_THR - 1; i++) fifo_get("R7 forward data");
        check("R7 svc low before threshold", {7'd0, svc_o}, 8'h00);
        fifo_get("R7 forward data");
        check("R7 svc set at threshold pop", {7'd0, svc_o}, 8'h01);
        fifo_get("R9 forward data");
        fifo_get("R9 forward data");
        check("R9 svc stays set", {7'd0, svc_o}, 8'h01);
        host_write(2'd2, 8'hC0);
        check("R9 host write 0 clears", {7'd0, svc_o}, 8'h00);
        for (int i = 0; i < DEPTH - WR_THR - 2; i++) fifo_get("R9 forward data");
        check("R9 no set without crossing", {7'd0, svc_o}, 8'h00);

        // R5 direct hop refused, other bits written.
        host_write(2'd2, 8'h68);
        ctrl_expect("R5 hop refused, bits written", 8'hC9);
        check("R13 dma_en_o", {7'd0, dma_en_o}, 8'h01);

        // R8 reverse threshold in test mode.
        dir_rev = 1'b1;
        host_write(2'd2, 8'hC0);
        for (int i = 0; i < RD_THR - 1; i++) fifo_put(8'(8'h50 + i), 1'b1);
        check("R8 svc low below read threshold", {7'd0, svc_o}, 8'h00);
        fifo_put(8'h5F, 1'b1);
        check("R8 svc set at read threshold", {7'd0, svc_o}, 8'h01);

        // R4 basic mode empties.
        host_write(2'd2, 8'h20);
        exp_q.delete();
        ctrl_expect("R4 bidirectional write empties", 8'h21);

        // R12 engine forward drain.
        dir_rev = 1'b0;
        host_write(2'd2, 8'h40);
        ctrl_expect("R1 FIFO mode code", 8'h41);
        fifo_put(8'h11, 1'b1); fifo_put(8'h22, 1'b1); fifo_put(8'h33, 1'b1);
        check("R12 eng_avail with data", {7'd0, eng_avail}, 8'h01);
        for (int i = 0; i < 3; i++) eng_take("R12 engine forward order");
        check("R12 eng_avail when drained", {7'd0, eng_avail}, 8'h00);

        fifo_put(8'h44, 1'b1); fifo_put(8'h55, 1'b1);
        host_write(2'd2, 8'h00);
        exp_q.delete();
        ctrl_expect("R4 standard write empties", 8'h01);

        // R12 engine reverse fill, host reads.
        host_write(2'd2, 8'h20);
        dir_rev = 1'b1;
        host_write(2'd2, 8'h60);
        ctrl_expect("R1 extended mode code", 8'h61);
        eng_give(8'h9A); eng_give(8'hBC);
        fifo_get("R12 reverse host read");
        fifo_get("R12 reverse host read");

        // R10 / R11 configuration bytes.
        host_read(2'd1);
        check("R10 config B hidden outside config", rd_v, 8'h00);
        dir_rev = 1'b0;
        host_write(2'd2, 8'h20);
        host_write(2'd2, 8'hE0);
        host_read(2'd0);
        check("R10 config A", rd_v, 8'h10);
        host_read(2'd1);
        check("R10 config B dma 3 irq 7", rd_v, 8'h0B);
        check("R11 irq 14 code 5 dma 1", alt_v, 8'h29);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule